// File: doc/BRIEF.md
# Dual-Phase PWM Timer

A single down-counting timer channel with a 32-bit register port. Software loads two reload values, one for a low phase and one for a high phase, then sets an enable bit. The counter takes the low-phase value at enable and steps down by one each clock. When it reaches zero it reloads and, in PWM mode, the output changes level. Each phase therefore lasts its reload value plus one clock, so the output can never sit at 0 % or 100 % duty while the timer runs.

The same counter also works as a plain interval timer. In user mode without PWM it always reloads the low-phase value. In free-running mode it wraps to all ones. Every terminal count sets a sticky interrupt flag. The flag reaches the interrupt pin unless masked, and a read of the clear register drops it. While disabled the counter holds its value and the output stays low.

Top module: `dual_phase_pwm_timer`

## Requirements
- R1: After reset every register reads zero and both `pwm_out` and `irq` are low.
- R2: Writing control with bit 0 (enable) rising loads the low reload value (offset 0x00) into the counter. With bit 1 = 1 (user mode) and bit 3 = 1 (PWM), the output is low for low-reload+1 cycles, then high for high-reload+1 cycles, and repeats.
- R3: With both reload values zero the output alternates level every clock. No phase is ever shorter than one clock.
- R4: Control occupies bits [3:0] at offset 0x08 and reads back as written: bit 0 enable, bit 1 mode (1 = user, 0 = free-running), bit 2 interrupt mask, bit 3 PWM select. The high reload value sits at 0xB0 + 4 × CHAN_IDX.
- R5: In user mode with PWM off, the counter reloads the low reload value at zero and the output stays low.
- R6: In free-running mode the counter reloads all ones at zero and the output stays low, even with the PWM bit set.
- R7: Each terminal count sets a sticky flag. `irq` and the status register (offset 0x10, bit 0) equal flag AND NOT mask.
- R8: Reading offset 0x0C clears the flag. Writes to the current-value (0x04), clear (0x0C) and status (0x10) offsets have no effect.
- R9: While disabled the counter holds its value and `pwm_out` is low. Reload values written while disabled are used from the next enable.
- R10: Offset 0x04 returns the live counter value, which falls by one per clock between reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the clear offset) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| pwm_out | output | 1 | PWM output, low while disabled |
| irq | output | 1 | Terminal-count interrupt, masked by control bit 2 |

## Verification
The assertions assume that software writes control with enable clear before it changes mode or reload values mid-run. They also assume a write and a read strobe are never raised in the same cycle. The bench keeps to this: every write or read task drives one strobe for exactly one cycle, and every reconfiguration is preceded by a disable write. The reload-value checks assume reload registers are stable while the counter is running, which the bench also respects.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   // channel-local byte offsets
   localparam int OFF_LOAD_LO = 'h00;
   localparam int OFF_CUR     = 'h04;
   localparam int OFF_CTRL    = 'h08;
   localparam int OFF_CLEAR   = 'h0C;
   localparam int OFF_STAT    = 'h10;
   localparam int HI_BANK     = 'hB0;
   localparam int HI_STRIDE   = 4;
   localparam int CTRL_W      = 4;

   // control field: bit3 pwm, bit2 mask, bit1 user mode, bit0 enable
   typedef struct packed {
      logic pwm;
      logic mask;
      logic user;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/dpt_regfile.sv
module dpt_regfile #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int CHAN_IDX = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   cnt,
   input  logic                flag,
   output logic [DATA_W-1:0]   rdata,
   output logic [DATA_W-1:0]   load_lo,
   output logic [DATA_W-1:0]   load_hi,
   output dpt_pkg::ctrl_t      ctrl,
   output logic                start,
   output logic                clr
);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(dpt_pkg::OFF_LOAD_LO);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(dpt_pkg::OFF_CUR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(dpt_pkg::OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(dpt_pkg::OFF_CLEAR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(dpt_pkg::OFF_STAT);
   localparam logic [ADDR_W-1:0] A_HI   =
      ADDR_W'(dpt_pkg::HI_BANK + dpt_pkg::HI_STRIDE * CHAN_IDX);
   localparam int PAD_W = DATA_W - dpt_pkg::CTRL_W;

   logic wr_lo, wr_hi, wr_ctrl;

   assign wr_lo   = wr && (addr == A_LO);
   assign wr_hi   = wr && (addr == A_HI);
   assign wr_ctrl = wr && (addr == A_CTRL);

   // enable rising edge through a control write
   assign start = wr_ctrl && wdata[0] && !ctrl.en;
   assign clr   = rd && (addr == A_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo <= '0;
         load_hi <= '0;
         ctrl    <= '0;
      end else begin
         if (wr_lo)   load_lo <= wdata;
         if (wr_hi)   load_hi <= wdata;
         if (wr_ctrl) ctrl    <= dpt_pkg::ctrl_t'(wdata[dpt_pkg::CTRL_W-1:0]);
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_LO)        rdata = load_lo;
      else if (addr == A_HI)   rdata = load_hi;
      else if (addr == A_CUR)  rdata = cnt;
      else if (addr == A_CTRL) rdata = {{PAD_W{1'b0}}, ctrl};
      else if (addr == A_STAT) rdata = {{(DATA_W-1){1'b0}}, flag & ~ctrl.mask};
   end
endmodule

// File: rtl/dpt_counter.sv
module dpt_counter #(
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               clr,
   input  dpt_pkg::ctrl_t     ctrl,
   input  logic [DATA_W-1:0]  load_lo,
   input  logic [DATA_W-1:0]  load_hi,
   output logic [DATA_W-1:0]  cnt,
   output logic               phase,
   output logic               flag
);
   logic at_zero, tick;

   assign at_zero = (cnt == '0);
   assign tick    = ctrl.en && !start && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (start) begin
         cnt   <= load_lo;
         phase <= 1'b0;
      end else if (ctrl.en) begin
         if (!at_zero) begin
            cnt <= cnt - DATA_W'(1);
         end else if (!ctrl.user) begin
            cnt <= '1;
         end else if (ctrl.pwm) begin
            cnt   <= phase ? load_lo : load_hi;
            phase <= ~phase;
         end else begin
            cnt <= load_lo;
         end
      end else begin
         phase <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (tick) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/dual_phase_pwm_timer.sv
module dual_phase_pwm_timer #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int CHAN_IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               pwm_out,
   output logic               irq
);
   localparam int HI_TOP = dpt_pkg::HI_BANK + dpt_pkg::HI_STRIDE * CHAN_IDX;

   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
         $error("DATA_W must be within 8..64");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must be at least 8");
      end
      if (CHAN_IDX < 0 || HI_TOP >= (1 << ADDR_W)) begin : g_bad_chan
         $error("CHAN_IDX places the high reload outside the address space");
      end
   endgenerate

   dpt_pkg::ctrl_t     ctrl_q;
   logic [DATA_W-1:0]  load_lo_q, load_hi_q, cnt_q;
   logic               start_p, clr_p, phase_q, flag_q;

   dpt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .rd      (reg_rd),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .cnt     (cnt_q),
      .flag    (flag_q),
      .rdata   (reg_rdata),
      .load_lo (load_lo_q),
      .load_hi (load_hi_q),
      .ctrl    (ctrl_q),
      .start   (start_p),
      .clr     (clr_p)
   );

   dpt_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_p),
      .clr     (clr_p),
      .ctrl    (ctrl_q),
      .load_lo (load_lo_q),
      .load_hi (load_hi_q),
      .cnt     (cnt_q),
      .phase   (phase_q),
      .flag    (flag_q)
   );

   assign pwm_out = ctrl_q.en & ctrl_q.pwm & ctrl_q.user & phase_q;
   assign irq     = flag_q & ~ctrl_q.mask;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
   parameter int DATA_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               user,
   input logic               pwm,
   input logic               mask,
   input logic               start,
   input logic               clr,
   input logic [DATA_W-1:0]  cnt,
   input logic [DATA_W-1:0]  load_lo,
   input logic               phase,
   input logic               flag,
   input logic               pwm_out,
   input logic               irq
);
   logic run_zero;
   assign run_zero = en && !start && (cnt == '0);

   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == $past(load_lo)) && !pwm_out);

   a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !start && cnt != '0) |=> cnt == $past(cnt) - DATA_W'(1));

   a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (run_zero && user && pwm) |=> phase != $past(phase));

   a_r5_user_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run_zero && user && !pwm) |=> cnt == $past(load_lo));

   a_r6_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_zero && !user) |=> (cnt == '1) && !pwm_out);

   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      run_zero |=> flag);

   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> !irq);

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !run_zero) |=> !flag);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !start) |=> $stable(cnt));

   a_r9_out_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm_out);
endmodule

bind dual_phase_pwm_timer dpt_checker #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (ctrl_q.en),
   .user    (ctrl_q.user),
   .pwm     (ctrl_q.pwm),
   .mask    (ctrl_q.mask),
   .start   (start_p),
   .clr     (clr_p),
   .cnt     (cnt_q),
   .load_lo (load_lo_q),
   .phase   (phase_q),
   .flag    (flag_q),
   .pwm_out (pwm_out),
   .irq     (irq)
);

// File: tb/dual_phase_pwm_timer_tb.sv
module dual_phase_pwm_timer_tb_top;
   localparam int DW = 32;
   localparam int AW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [DW-1:0]  reg_rdata;
   logic           pwm_out, irq;

   int n_chk = 0, n_fail = 0;
   logic mon_on = 1'b0;
   logic done = 1'b0;

   typedef struct {
      logic  lvl;
      int    len;
      string req;
   } run_t;
   run_t exp_q[$];

   always #2.5 clk = ~clk;

   dual_phase_pwm_timer #(.DATA_W(DW), .ADDR_W(AW), .CHAN_IDX(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit arm = 0);
      @(negedge clk);
      if (arm) mon_on = 1'b1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic push_run(input logic lvl, input int len, input string req);
      run_t it;
      it.lvl = lvl; it.len = len; it.req = req;
      exp_q.push_back(it);
   endtask

   // monitor: measures output run lengths and compares against the queue
   initial begin
      logic cur_lvl;
      int   run_len;
      run_len = 0;
      cur_lvl = 1'b0;
      forever begin
         @(posedge clk); #1;
         if (!mon_on) begin
            run_len = 0;
         end else if (run_len == 0) begin
            cur_lvl = pwm_out; run_len = 1;
         end else if (pwm_out == cur_lvl) begin
            run_len++;
         end else begin
            if (exp_q.size() > 0) begin
               run_t it;
               it = exp_q.pop_front();
               n_chk++;
               if (it.lvl !== cur_lvl || it.len != run_len) begin
                  n_fail++;
                  $display("FAIL %s run actual=%0b/%0d expected=%0b/%0d",
                           it.req, cur_lvl, run_len, it.lvl, it.len);
               end
            end
            cur_lvl = pwm_out; run_len = 1;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v, v2;
      logic [DW-1:0] vmax;
      logic          out_seen;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); chk("R1 load lo", v, 0);
      rd(8'hB0, v); chk("R1 load hi", v, 0);
      rd(8'h04, v); chk("R1 current", v, 0);
      rd(8'h08, v); chk("R1 ctrl", v, 0);
      rd(8'h10, v); chk("R1 status", v, 0);
      chk("R1 pwm_out", {31'd0, pwm_out}, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R4 field layout and addresses
      wr(8'h08, 32'hE); rd(8'h08, v); chk("R4 ctrl readback", v, 32'hE);
      wr(8'h00, 32'd3); rd(8'h00, v); chk("R4 load lo", v, 32'd3);
      wr(8'hB0, 32'd6); rd(8'hB0, v); chk("R4 load hi at 0xB0", v, 32'd6);
      wr(8'h08, 32'hA);

      // R2 phase lengths lo=3 hi=6
      push_run(1'b0, 4, "R2"); push_run(1'b1, 7, "R2");
      push_run(1'b0, 4, "R2"); push_run(1'b1, 7, "R2");
      wr(8'h08, 32'hB, 1);
      repeat (30) @(negedge clk);
      mon_on = 1'b0;
      chk("R2 all runs seen", exp_q.size(), 0);
      chk("R7 irq after terminal count", {31'd0, irq}, 1);
      rd(8'h10, v); chk("R7 status", v, 1);

      // disable; flag stays sticky
      wr(8'h08, 32'hA);
      chk("R9 out low when disabled", {31'd0, pwm_out}, 0);
      chk("R7 flag sticky", {31'd0, irq}, 1);
      wr(8'h08, 32'hE);
      chk("R7 masked irq", {31'd0, irq}, 0);
      rd(8'h10, v); chk("R7 masked status", v, 0);
      wr(8'h08, 32'hA);
      chk("R7 unmasked again", {31'd0, irq}, 1);
      rd(8'h0C, v);
      chk("R8 clear read drops irq", {31'd0, irq}, 0);

      // R9 hold and deferred reload
      rd(8'h04, v);
      repeat (5) @(negedge clk);
      rd(8'h04, v2);
      chk("R9 counter holds", v2, v);
      wr(8'h00, 32'd1); wr(8'hB0, 32'd2);
      chk("R9 out still low", {31'd0, pwm_out}, 0);
      push_run(1'b0, 2, "R9"); push_run(1'b1, 3, "R9");
      push_run(1'b0, 2, "R9"); push_run(1'b1, 3, "R9");
      wr(8'h08, 32'hB, 1);
      repeat (16) @(negedge clk);
      mon_on = 1'b0;
      chk("R9 new reloads used", exp_q.size(), 0);
      wr(8'h08, 32'hA);

      // R3 minimum phases
      wr(8'h00, 32'd0); wr(8'hB0, 32'd0);
      for (int i = 0; i < 3; i++) begin
         push_run(1'b0, 1, "R3"); push_run(1'b1, 1, "R3");
      end
      wr(8'h08, 32'hB, 1);
      repeat (10) @(negedge clk);
      mon_on = 1'b0;
      chk("R3 single-cycle phases", exp_q.size(), 0);
      wr(8'h08, 32'hA);

      // R10 live counter, R5 user mode without PWM
      wr(8'h00, 32'd20); wr(8'hB0, 32'd100);
      wr(8'h08, 32'h3);
      rd(8'h04, v);
      repeat (4) @(negedge clk);
      rd(8'h04, v2);
      chk("R10 live value after enable", v, 32'd20);
      chk("R10 value five cycles later", v2, 32'd15);
      vmax = 0; out_seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         rd(8'h04, v);
         if (v > vmax) vmax = v;
         if (pwm_out) out_seen = 1'b1;
      end
      chk("R5 reload from low value", vmax, 32'd20);
      chk("R5 output stays low", {31'd0, out_seen}, 0);
      wr(8'h08, 32'h2);

      // R6 free-running wraps to all ones, PWM bit inert
      wr(8'h00, 32'd2);
      wr(8'h08, 32'h9);
      rd(8'h04, v);  chk("R6 loaded", v, 32'd2);
      rd(8'h04, v);  rd(8'h04, v);
      rd(8'h04, v);  chk("R6 wrap", v, 32'hFFFF_FFFF);
      rd(8'h04, v);  chk("R6 after wrap", v, 32'hFFFF_FFFE);
      chk("R6 output low", {31'd0, pwm_out}, 0);
      chk("R7 free-mode irq", {31'd0, irq}, 1);
      wr(8'h08, 32'h0);

      // R8 read-only offsets ignore writes
      rd(8'h04, v);
      wr(8'h04, 32'h55);
      wr(8'h10, 32'h1);
      wr(8'h0C, 32'h0);
      rd(8'h04, v2);
      chk("R8 current ignores write", v2, v);
      chk("R8 clear write leaves flag", {31'd0, irq}, 1);
      rd(8'h08, v);
      chk("R8 ctrl unchanged", v, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule